// File: doc/BRIEF.md
# Debug Breakpoint and Execution Controller

This block sits beside a processor core and decides, every cycle, whether the core may advance. A debugger drives it through a small command port with five commands: resume, stop, advance by exactly one instruction, and pass over one instruction without keeping its results. A fifth command clears the recorded hits. The core reports its current program address and a one-cycle pulse at the end of each instruction. For each of its memory spaces it also reports the address, data, read strobe and write strobe.

A bank of breakpoint slots watches those buses. Each slot is loaded through a configuration port with a kind, a memory space, an address and, for the data-qualified kinds, a data value. A slot can match on an instruction address, or on any read or any write of an address. It can also match on a read or write that carries one exact data value. When a slot matches while the core runs freely, the controller lets the current instruction finish and then stops the core. It also records the hit in a per-slot flag, which stays set until the debugger clears it. When no slot is armed, the comparator operands are held at zero so that the comparators do not toggle.

Top module: `dbg_exec_bp`

## Requirements
- R1: After reset, `cpu_run` is 1, `insn_kill` is 0, every `bp_hit` bit is 0 and every slot is disarmed.
- R2: The stop command (`cmd_code` 2) makes `cpu_run` 0 from the next cycle, whatever the state. It wins over an instruction end, a match or a pending hit in the same cycle.
- R3: The resume command (`cmd_code` 1), given while stopped, makes `cpu_run` 1 from the next cycle, and the core then runs freely.
- R4: The one-step command (`cmd_code` 3), given while stopped, makes `cpu_run` 1 from the next cycle. It keeps it there up to and including the first cycle with `insn_end`, and makes it 0 in the cycle after.
- R5: The pass-over command (`cmd_code` 4), given while stopped, behaves like one-step, with `insn_kill` 1 for exactly the cycles in which `cpu_run` is 1. Bus activity during those cycles never sets a hit flag.
- R6: Kind 1 matches while the program address equals the low program-address bits of the slot address. In free run, any match stops the core in the cycle after the next `insn_end`, counting an `insn_end` in the same cycle as the match.
- R7: Kind 2 matches a read strobe, and kind 3 a write strobe, in the slot's space whose address equals the slot address. The space encoding is 0 program memory, 1 internal data, 2 special function registers and 3 external data. The data value plays no part.
- R8: Kind 4 (read) and kind 5 (write) match as kinds 2 and 3 do, and also require the bus data to equal the slot data.
- R9: A match sets that slot's `bp_hit` bit from the next cycle. The bit stays set until a clear command (`cmd_code` 5). A match in the same cycle as the clear leaves the bit set.
- R10: Resume, one-step and pass-over commands are ignored while the core is not stopped. In particular, a one-step given during free run does not stop the core at the next `insn_end`.
- R11: A slot of kind 0, 6 or 7 never matches. An access in a space other than the slot's space never matches.
- R12: Matches are evaluated only in free run and during a one-step. Bus activity while stopped sets no hit bit. A configuration write applies from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | 1 resume, 2 stop, 3 one-step, 4 pass-over, 5 clear hits |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | SLW | Slot written |
| cfg_kind | input | 3 | Match kind 0..5 |
| cfg_space | input | SPW | Memory space watched |
| cfg_addr | input | AW | Address to match |
| cfg_data | input | DW | Data to match (kinds 4 and 5) |
| pc | input | PC_W | Address of the instruction in progress |
| insn_end | input | 1 | Last cycle of the current instruction |
| mem_addr | input | NSPC*AW | Per-space address, space s at bits s*AW |
| mem_data | input | NSPC*DW | Per-space data, space s at bits s*DW |
| mem_rd | input | NSPC | Per-space read strobe |
| mem_wr | input | NSPC | Per-space write strobe |
| cpu_run | output | 1 | Core may advance |
| insn_kill | output | 1 | Current instruction must not commit |
| bp_hit | output | NBP | Sticky per-slot hit flags |

## Verification
Two pairs of events can fall in the same cycle. The first is a slot match together with the `insn_end` pulse in free run: the bench holds the program address on a watched value in the very cycle that ends the instruction, and expects the stop one cycle later, not one instruction later. The second is a clear command together with a fresh match: the bench raises both strobes in one cycle and expects the flag to survive. A behavioural model in the bench also runs long random stretches that mix commands, slot rewrites, instruction ends and bus strobes on a small address set. It compares every output on every clock, so these overlaps and a stop command landing on a boundary occur many times.

// File: rtl/dbg_exec_pkg.sv
package dbg_exec_pkg;
   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_RUN   = 3'd1,
      CMD_HALT  = 3'd2,
      CMD_STEP  = 3'd3,
      CMD_SKIP  = 3'd4,
      CMD_CLEAR = 3'd5
   } dbg_cmd_e;

   typedef enum logic [2:0] {
      BK_OFF     = 3'd0,
      BK_PC      = 3'd1,
      BK_RD      = 3'd2,
      BK_WR      = 3'd3,
      BK_RD_DATA = 3'd4,
      BK_WR_DATA = 3'd5
   } bp_kind_e;

   typedef enum logic [1:0] {
      EX_RUN  = 2'd0,
      EX_HALT = 2'd1,
      EX_STEP = 2'd2,
      EX_SKIP = 2'd3
   } ex_state_e;
endpackage

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot
   import dbg_exec_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int AW   = 24,
   parameter int DW   = 8,
   parameter int NSPC = 4,
   localparam int SPW = (NSPC > 1) ? $clog2(NSPC) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_kind,
   input  logic [SPW-1:0]       cfg_space,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [DW-1:0]        cfg_data,
   input  logic                 cmp_on,
   input  logic [PC_W-1:0]      pc,
   input  logic [NSPC*AW-1:0]   mem_addr,
   input  logic [NSPC*DW-1:0]   mem_data,
   input  logic [NSPC-1:0]      mem_rd,
   input  logic [NSPC-1:0]      mem_wr,
   output logic                 armed,
   output logic                 match
);
   bp_kind_e       kind_q;
   logic [SPW-1:0] space_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q  <= BK_OFF;
         space_q <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else if (cfg_we) begin
         kind_q  <= bp_kind_e'(cfg_kind);
         space_q <= cfg_space;
         addr_q  <= cfg_addr;
         data_q  <= cfg_data;
      end
   end

   // per-space views of the buses
   logic [AW-1:0] a_arr [NSPC];
   logic [DW-1:0] d_arr [NSPC];
   for (genvar s = 0; s < NSPC; s++) begin : g_unpack
      assign a_arr[s] = mem_addr[s*AW +: AW];
      assign d_arr[s] = mem_data[s*DW +: DW];
   end

   // operand isolation: comparators see zeros when compare is off
   logic [AW-1:0]   op_addr;
   logic [DW-1:0]   op_data;
   logic [PC_W-1:0] op_pc;
   logic            op_rd, op_wr;
   always_comb begin
      op_addr = cmp_on ? a_arr[space_q]  : '0;
      op_data = cmp_on ? d_arr[space_q]  : '0;
      op_pc   = cmp_on ? pc              : '0;
      op_rd   = cmp_on & mem_rd[space_q];
      op_wr   = cmp_on & mem_wr[space_q];
   end

   logic addr_eq, data_eq, pc_eq;
   assign addr_eq = (op_addr == addr_q);
   assign data_eq = (op_data == data_q);
   assign pc_eq   = (op_pc == addr_q[PC_W-1:0]);

   always_comb begin
      unique case (kind_q)
         BK_PC:      match = cmp_on & pc_eq;
         BK_RD:      match = op_rd & addr_eq;
         BK_WR:      match = op_wr & addr_eq;
         BK_RD_DATA: match = op_rd & addr_eq & data_eq;
         BK_WR_DATA: match = op_wr & addr_eq & data_eq;
         default:    match = 1'b0;
      endcase
   end

   assign armed = (kind_q inside {BK_PC, BK_RD, BK_WR, BK_RD_DATA, BK_WR_DATA});
endmodule

// File: rtl/dbg_exec_fsm.sv
module dbg_exec_fsm
   import dbg_exec_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       insn_end,
   input  logic       bp_fire,
   output logic       cpu_run,
   output logic       insn_kill,
   output logic       eval_en,
   output logic [1:0] state_o
);
   ex_state_e st_q, st_d;
   logic      pend_q, pend_d;
   logic      c_halt, c_run, c_step, c_skip;

   assign c_halt = cmd_valid && (cmd_code == CMD_HALT);
   assign c_run  = cmd_valid && (cmd_code == CMD_RUN);
   assign c_step = cmd_valid && (cmd_code == CMD_STEP);
   assign c_skip = cmd_valid && (cmd_code == CMD_SKIP);

   always_comb begin
      st_d = st_q;
      if (c_halt) begin
         st_d = EX_HALT;
      end else begin
         unique case (st_q)
            EX_HALT: begin
               if (c_run)       st_d = EX_RUN;
               else if (c_step) st_d = EX_STEP;
               else if (c_skip) st_d = EX_SKIP;
            end
            EX_RUN:  if (insn_end && (pend_q || bp_fire)) st_d = EX_HALT;
            default: if (insn_end) st_d = EX_HALT;
         endcase
      end
      // a match remembered until the end of the instruction in free run
      pend_d = (st_q == EX_RUN) && (st_d == EX_RUN) && !insn_end && (pend_q || bp_fire);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= EX_RUN;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
      end
   end

   assign cpu_run   = (st_q != EX_HALT);
   assign insn_kill = (st_q == EX_SKIP);
   assign eval_en   = (st_q == EX_RUN) || (st_q == EX_STEP);
   assign state_o   = st_q;
endmodule

// File: rtl/dbg_exec_bp.sv
module dbg_exec_bp
   import dbg_exec_pkg::*;
#(
   parameter int NBP       = 4,
   parameter int PC_W      = 16,
   parameter int AW        = 24,
   parameter int DW        = 8,
   parameter int NSPC      = 4,
   parameter bit GATE_IDLE = 1'b1,
   localparam int SLW = (NBP > 1) ? $clog2(NBP) : 1,
   localparam int SPW = (NSPC > 1) ? $clog2(NSPC) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_code,
   input  logic                 cfg_we,
   input  logic [SLW-1:0]       cfg_slot,
   input  logic [2:0]           cfg_kind,
   input  logic [SPW-1:0]       cfg_space,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [DW-1:0]        cfg_data,
   input  logic [PC_W-1:0]      pc,
   input  logic                 insn_end,
   input  logic [NSPC*AW-1:0]   mem_addr,
   input  logic [NSPC*DW-1:0]   mem_data,
   input  logic [NSPC-1:0]      mem_rd,
   input  logic [NSPC-1:0]      mem_wr,
   output logic                 cpu_run,
   output logic                 insn_kill,
   output logic [NBP-1:0]       bp_hit
);
   if (NBP < 1 || DW < 1 || PC_W < 1 || PC_W > AW || NSPC < 2 || (1 << SPW) != NSPC) begin : g_bad_cfg
      $error("dbg_exec_bp: illegal parameter set");
   end

   logic           eval_en, cmp_on, any_armed, bp_fire, clr;
   logic [1:0]     ex_state;
   logic [NBP-1:0] armed_v, match_v, hit_q;

   assign any_armed = |armed_v;

   if (GATE_IDLE) begin : g_gate
      assign cmp_on = eval_en & any_armed;
   end else begin : g_nogate
      assign cmp_on = eval_en;
   end

   for (genvar i = 0; i < NBP; i++) begin : g_slot
      dbg_bp_slot #(.PC_W(PC_W), .AW(AW), .DW(DW), .NSPC(NSPC)) u_slot (
         .clk      (clk),
         .rst      (rst),
         .cfg_we   (cfg_we && (cfg_slot == SLW'(i))),
         .cfg_kind (cfg_kind),
         .cfg_space(cfg_space),
         .cfg_addr (cfg_addr),
         .cfg_data (cfg_data),
         .cmp_on   (cmp_on),
         .pc       (pc),
         .mem_addr (mem_addr),
         .mem_data (mem_data),
         .mem_rd   (mem_rd),
         .mem_wr   (mem_wr),
         .armed    (armed_v[i]),
         .match    (match_v[i])
      );
   end

   assign bp_fire = |match_v;

   dbg_exec_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .cmd_valid(cmd_valid),
      .cmd_code (cmd_code),
      .insn_end (insn_end),
      .bp_fire  (bp_fire),
      .cpu_run  (cpu_run),
      .insn_kill(insn_kill),
      .eval_en  (eval_en),
      .state_o  (ex_state)
   );

   assign clr = cmd_valid && (cmd_code == CMD_CLEAR);

   always_ff @(posedge clk) begin
      if (rst) hit_q <= '0;
      else     hit_q <= (hit_q & ~{NBP{clr}}) | match_v;
   end

   assign bp_hit = hit_q;
endmodule

// File: rtl/dbg_exec_bp_chk.sv
module dbg_exec_bp_chk #(
   parameter int NBP = 4
) (
   input logic           clk,
   input logic           rst,
   input logic           cmd_valid,
   input logic [2:0]     cmd_code,
   input logic           insn_end,
   input logic           cpu_run,
   input logic           insn_kill,
   input logic [1:0]     ex_state,
   input logic [NBP-1:0] bp_hit
);
   logic k_halt, k_clr, k_go;
   assign k_halt = cmd_valid && (cmd_code == 3'd2);
   assign k_clr  = cmd_valid && (cmd_code == 3'd5);
   assign k_go   = cmd_valid && (cmd_code == 3'd1 || cmd_code == 3'd3 || cmd_code == 3'd4);

   a_r2_halt_cmd: assert property (@(posedge clk) disable iff (rst)
      k_halt |=> !cpu_run);

   a_r4_step_stops: assert property (@(posedge clk) disable iff (rst)
      (ex_state == 2'd2 && insn_end) |=> !cpu_run);

   a_r5_kill_while_running: assert property (@(posedge clk) disable iff (rst)
      insn_kill |-> cpu_run);

   a_r5_skip_no_hit: assert property (@(posedge clk) disable iff (rst)
      (insn_kill && !k_clr) |=> (bp_hit == $past(bp_hit)));

   a_r9_hit_sticky: assert property (@(posedge clk) disable iff (rst)
      !k_clr |=> ((bp_hit & $past(bp_hit)) == $past(bp_hit)));

   a_r12_halted_hold: assert property (@(posedge clk) disable iff (rst)
      (!cpu_run && !k_go) |=> !cpu_run);

   a_r12_halted_no_new_hit: assert property (@(posedge clk) disable iff (rst)
      (!cpu_run && !k_clr) |=> (bp_hit == $past(bp_hit)));
endmodule

bind dbg_exec_bp dbg_exec_bp_chk #(.NBP(NBP)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cmd_valid(cmd_valid),
   .cmd_code (cmd_code),
   .insn_end (insn_end),
   .cpu_run  (cpu_run),
   .insn_kill(insn_kill),
   .ex_state (ex_state),
   .bp_hit   (bp_hit)
);

// File: tb/dbg_exec_bp_bench.sv
`timescale 1ns/1ps
module dbg_exec_bp_bench;
   localparam int NBP = 4, PC_W = 16, AW = 24, DW = 8, NSPC = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst, cmd_valid, cfg_we, insn_end;
   logic [2:0]         cmd_code, cfg_kind;
   logic [1:0]         cfg_slot, cfg_space;
   logic [AW-1:0]      cfg_addr;
   logic [DW-1:0]      cfg_data;
   logic [PC_W-1:0]    pc;
   logic [NSPC*AW-1:0] mem_addr;
   logic [NSPC*DW-1:0] mem_data;
   logic [NSPC-1:0]    mem_rd, mem_wr;
   logic               cpu_run, insn_kill;
   logic [NBP-1:0]     bp_hit;

   dbg_exec_bp u_dbg_exec_bp (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind), .cfg_space(cfg_space),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .pc(pc), .insn_end(insn_end),
      .mem_addr(mem_addr), .mem_data(mem_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .cpu_run(cpu_run), .insn_kill(insn_kill), .bp_hit(bp_hit)
   );

   int    vectors = 0, miscompares = 0, cycles = 0;
   string tag = "R1";

   // behavioural reference: 0 running, 1 stopped, 2 one-step, 3 pass-over
   int             m_st;
   bit             m_pend;
   bit [NBP-1:0]   m_hit;
   int             m_kind [NBP];
   int             m_sp   [NBP];
   logic [AW-1:0]  m_addr [NBP];
   logic [DW-1:0]  m_dat  [NBP];

   function automatic bit slot_hit(int s);
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = mem_addr[m_sp[s]*AW +: AW];
      d = mem_data[m_sp[s]*DW +: DW];
      case (m_kind[s])
         1: return pc == m_addr[s][PC_W-1:0];
         2: return mem_rd[m_sp[s]] && a == m_addr[s];
         3: return mem_wr[m_sp[s]] && a == m_addr[s];
         4: return mem_rd[m_sp[s]] && a == m_addr[s] && d == m_dat[s];
         5: return mem_wr[m_sp[s]] && a == m_addr[s] && d == m_dat[s];
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk) begin
      bit [NBP-1:0] mv;
      bit           fire, clr;
      int           nxt;
      if (rst) begin
         m_st = 0; m_pend = 0; m_hit = '0;
         for (int s = 0; s < NBP; s++) begin
            m_kind[s] = 0; m_sp[s] = 0; m_addr[s] = '0; m_dat[s] = '0;
         end
      end else begin
         mv = '0;
         if (m_st == 0 || m_st == 2)
            for (int s = 0; s < NBP; s++) mv[s] = slot_hit(s);
         fire = |mv;
         clr  = cmd_valid && cmd_code == 3'd5;
         m_hit = clr ? mv : (m_hit | mv);
         nxt = m_st;
         if (cmd_valid && cmd_code == 3'd2) nxt = 1;
         else if (m_st == 1) begin
            if (cmd_valid && cmd_code == 3'd1) nxt = 0;
            else if (cmd_valid && cmd_code == 3'd3) nxt = 2;
            else if (cmd_valid && cmd_code == 3'd4) nxt = 3;
         end else if (m_st == 0) begin
            if (insn_end && (m_pend || fire)) nxt = 1;
         end else if (insn_end) nxt = 1;
         m_pend = (m_st == 0 && nxt == 0) ? (!insn_end && (m_pend || fire)) : 1'b0;
         m_st = nxt;
         if (cfg_we) begin
            m_kind[cfg_slot] = int'(cfg_kind);
            m_sp[cfg_slot]   = int'(cfg_space);
            m_addr[cfg_slot] = cfg_addr;
            m_dat[cfg_slot]  = cfg_data;
         end
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (!rst) begin
         vectors++;
         if (cpu_run !== (m_st != 1) || insn_kill !== (m_st == 3) || bp_hit !== m_hit) begin
            miscompares++;
            $display("FAIL %s: run/kill/hit got %b/%b/%b expected %b/%b/%b", tag,
                     cpu_run, insn_kill, bp_hit, (m_st != 1), (m_st == 3), m_hit);
         end
      end
   end

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(negedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         miscompares++;
         $display("FAIL watchdog: got %0d cycles expected under 50000", cycles);
         finish_run();
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(bit ok, string t, int got, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: got %0h expected %0h", t, got, exp);
      end
   endtask

   task automatic send(int c);
      cmd_valid = 1'b1; cmd_code = 3'(c);
      tick();
      cmd_valid = 1'b0; cmd_code = 3'd0;
   endtask

   task automatic setbp(int s, int k, int sp, int a, int d);
      cfg_we = 1'b1; cfg_slot = 2'(s); cfg_kind = 3'(k); cfg_space = 2'(sp);
      cfg_addr = AW'(a); cfg_data = DW'(d);
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic acc(int sp, int a, int d, bit rd, bit wr);
      mem_addr[sp*AW +: AW] = AW'(a);
      mem_data[sp*DW +: DW] = DW'(d);
      mem_rd[sp] = rd; mem_wr[sp] = wr;
      tick();
      mem_rd = '0; mem_wr = '0;
   endtask

   task automatic end_insn();
      insn_end = 1'b1;
      tick();
      insn_end = 1'b0;
   endtask

   initial begin
      rst = 1'b1; cmd_valid = 0; cmd_code = 0; cfg_we = 0; cfg_slot = 0; cfg_kind = 0;
      cfg_space = 0; cfg_addr = 0; cfg_data = 0; pc = 0; insn_end = 0;
      mem_addr = '0; mem_data = '0; mem_rd = '0; mem_wr = '0;
      repeat (3) tick();
      rst = 1'b0;
      tick();
      tag = "R1";
      chk(cpu_run == 1 && insn_kill == 0 && bp_hit == 0, "R1 reset state", {cpu_run, insn_kill, bp_hit}, 6'b100000);

      tag = "R2";
      send(2);
      chk(cpu_run == 0, "R2 stop command", cpu_run, 0);

      tag = "R12";
      setbp(1, 2, 1, 'h40, 0);
      acc(1, 'h40, 0, 1, 0);
      chk(bp_hit == 0, "R12 no hit while stopped", bp_hit, 0);

      tag = "R4";
      send(3);
      chk(cpu_run == 1, "R4 step starts", cpu_run, 1);
      tick();
      tag = "R7";
      acc(1, 'h40, 'h77, 1, 0);
      chk(bp_hit == 4'b0010, "R7 read any data", bp_hit, 4'b0010);
      tag = "R4";
      end_insn();
      chk(cpu_run == 0, "R4 step halts after end", cpu_run, 0);

      tag = "R9";
      send(5);
      chk(bp_hit == 0, "R9 clear", bp_hit, 0);

      tag = "R5";
      send(4);
      chk(cpu_run == 1 && insn_kill == 1, "R5 skip kill", {cpu_run, insn_kill}, 2'b11);
      acc(1, 'h40, 0, 1, 0);
      chk(bp_hit == 0, "R5 no hit while skipping", bp_hit, 0);
      end_insn();
      chk(cpu_run == 0 && insn_kill == 0, "R5 skip ends", {cpu_run, insn_kill}, 0);

      tag = "R3";
      send(1);
      chk(cpu_run == 1, "R3 resume", cpu_run, 1);
      tag = "R10";
      send(3);
      end_insn();
      chk(cpu_run == 1, "R10 step ignored in run", cpu_run, 1);
      send(4);
      chk(insn_kill == 0, "R10 skip ignored in run", insn_kill, 0);

      tag = "R6";
      setbp(0, 1, 0, 'h0123, 0);
      pc = 16'h0123;
      tick();
      pc = 16'h0124;
      tick();
      chk(cpu_run == 1, "R6 runs until end", cpu_run, 1);
      end_insn();
      chk(cpu_run == 0 && bp_hit[0] == 1, "R6 pc halt", {cpu_run, bp_hit[0]}, 2'b01);
      send(1);
      pc = 16'h0123; insn_end = 1'b1;
      tick();
      insn_end = 1'b0; pc = 16'h0000;
      chk(cpu_run == 0, "R6 match on boundary", cpu_run, 0);

      tag = "R11";
      send(5); send(1);
      setbp(2, 3, 3, 'hABCDE, 0);
      acc(2, 'hABCDE, 'h55, 0, 1);
      chk(bp_hit == 0, "R11 other space", bp_hit, 0);
      tag = "R7";
      acc(3, 'hABCDE, 'h55, 0, 1);
      chk(bp_hit == 4'b0100, "R7 write any data", bp_hit, 4'b0100);
      end_insn();
      send(1);

      tag = "R8";
      setbp(3, 5, 2, 'h90, 'hA5);
      acc(2, 'h90, 'h5A, 0, 1);
      chk(bp_hit[3] == 0, "R8 write data mismatch", bp_hit[3], 0);
      acc(2, 'h90, 'hA5, 1, 0);
      chk(bp_hit[3] == 0, "R8 read ignored for write kind", bp_hit[3], 0);
      acc(2, 'h90, 'hA5, 0, 1);
      chk(bp_hit[3] == 1, "R8 write data match", bp_hit[3], 1);
      end_insn();
      send(5); send(1);
      setbp(3, 4, 0, 'h2000, 'h11);
      acc(0, 'h2000, 'h12, 1, 0);
      chk(bp_hit[3] == 0, "R8 read data mismatch", bp_hit[3], 0);
      acc(0, 'h2000, 'h11, 1, 0);
      chk(bp_hit[3] == 1, "R8 read data match", bp_hit[3], 1);
      end_insn();
      send(1);

      tag = "R9";
      cmd_valid = 1'b1; cmd_code = 3'd5;
      acc(0, 'h2000, 'h11, 1, 0);
      cmd_valid = 1'b0; cmd_code = 3'd0;
      chk(bp_hit == 4'b1000, "R9 match beats clear", bp_hit, 4'b1000);
      end_insn();

      tag = "R2";
      send(3);
      cmd_valid = 1'b1; cmd_code = 3'd2; insn_end = 1'b1;
      tick();
      cmd_valid = 1'b0; cmd_code = 3'd0; insn_end = 1'b0;
      chk(cpu_run == 0, "R2 stop with boundary", cpu_run, 0);

      tag = "R11";
      send(5); send(1);
      setbp(1, 0, 1, 'h40, 0);
      setbp(2, 7, 3, 'hABCDE, 0);
      acc(1, 'h40, 0, 1, 0);
      acc(3, 'hABCDE, 0, 0, 1);
      chk(bp_hit == 0, "R11 disarmed slots", bp_hit, 0);

      // random stretch, reference compared on every clock
      tag = "random";
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         cmd_valid = (r < 12); cmd_code = 3'($urandom_range(0, 5));
         cfg_we = ($urandom_range(0, 99) < 4);
         cfg_slot = 2'($urandom_range(0, 3)); cfg_kind = 3'($urandom_range(0, 7));
         cfg_space = 2'($urandom_range(0, 3)); cfg_addr = AW'($urandom_range(0, 3));
         cfg_data = DW'($urandom_range(0, 3));
         pc = PC_W'($urandom_range(0, 7));
         insn_end = ($urandom_range(0, 3) == 0);
         for (int s = 0; s < NSPC; s++) begin
            mem_addr[s*AW +: AW] = AW'($urandom_range(0, 3));
            mem_data[s*DW +: DW] = DW'($urandom_range(0, 3));
         end
         mem_rd = 4'($urandom_range(0, 15));
         mem_wr = 4'($urandom_range(0, 15));
         tick();
      end
      cmd_valid = 0; cfg_we = 0; insn_end = 0; mem_rd = '0; mem_wr = '0;
      tick();
      finish_run();
   end
endmodule